// File: doc/BRIEF.md
# Credit-Issuing Flit Receiver Controller

This block sits at the receive end of a one-way link that moves fixed-width flits under credit flow control. It answers the transmitter's activation request with an acknowledge. When the link comes up, it grants the transmitter a fixed number of link credits, one per cycle. It captures one flit on every cycle in which the flit-valid input is high and the flit is allowed. Each captured flit goes into a local buffer that holds exactly as many flits as there are credits.

The flit at the head of the buffer is offered upward on a valid/ready interface. A 16-bit CRC sits in the top bits of each flit, and the block checks it before the flit leaves. A flit whose CRC fails is still forwarded, with an error flag set. Every flit that leaves the buffer earns the transmitter one credit back. When the request falls, the acknowledge is held until the buffer is empty. The next activation then starts again with a full credit grant. A flit that arrives outside an active link, or without a credit, is discarded and reported on a protocol-error output.

The protocol-type byte and the 40-bit header below the CRC are carried through unchanged. The payload below them is also carried through unchanged.

Top module: `flit_rx_ctrl`

## Requirements
- R1: While rst_n is low, act_ack_o, credit_o, up_valid_o and proto_err_o are all low, whatever act_req_i and flit_valid_i do.
- R2: When act_req_i is sampled high while act_ack_o is low, act_ack_o is high from the next cycle.
- R3: After act_ack_o rises with act_req_i still high and nothing drained, credit_o is high for exactly INIT_CREDITS consecutive cycles, one credit per high cycle, and then stays low.
- R4: credit_o is never high unless act_req_i and act_ack_o are both high.
- R5: An accepted flit appears on up_flit_o in arrival order. While up_valid_o is high and up_ready_i is low, up_valid_o stays high and up_flit_o stays unchanged.
- R6: Each flit drained (up_valid_o and up_ready_i high together) while act_ack_o is high adds one further credit pulse.
- R7: The CRC occupies bits [FLIT_W-1:FLIT_W-16]. It is computed over bits FLIT_W-17 down to 0, in that order. The polynomial is 0x1021, the start value is 0xFFFF, and there is no reflection and no final XOR. up_crc_err_o is high with the head flit exactly when the stored CRC differs from the computed one, and such a flit is still delivered.
- R8: The buffer holds INIT_CREDITS flits. Sending one flit per granted credit, with no draining, loses no flit.
- R9: When act_req_i falls, act_ack_o stays high until the buffer has been seen empty, then drops on the next cycle. Credits not yet used are forfeited, and the next activation grants a full INIT_CREDITS again.
- R10: A flit_valid_i cycle while the link is not active (act_req_i and act_ack_o both high), or while the transmitter holds no unused credit, is discarded. It raises proto_err_o for the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_req_i | input | 1 | Transmitter activation request |
| act_ack_o | output | 1 | Activation acknowledge |
| flit_valid_i | input | 1 | Flit present this cycle |
| flit_i | input | FLIT_W | Incoming flit |
| credit_o | output | 1 | One link credit per high cycle |
| up_valid_o | output | 1 | Head flit available upward |
| up_ready_i | input | 1 | Upper layer takes the head flit |
| up_flit_o | output | FLIT_W | Head flit |
| up_crc_err_o | output | 1 | Head flit failed its CRC |
| proto_err_o | output | 1 | Previous cycle carried a disallowed flit |

## Verification
Wrong credit bookkeeping shows up in the pulse count on credit_o within a few cycles of activation or draining. Too many pulses let the bench push a flit the block then flags as disallowed. Too few pulses leave the grant total short of INIT_CREDITS. A broken buffer pointer or count surfaces at the next drain as a flit out of order, a missing flit, or a stale flit. A mishandled deactivation is visible as an acknowledge that drops while flits still wait, or that never drops once the buffer is empty.

// File: rtl/flit_rx_ctrl.sv
`timescale 1ns/1ps
module flit_rx_ctrl #(
  parameter int FLIT_W       = 256,
  parameter int INIT_CREDITS = 8,
  parameter int BUF_DEPTH    = INIT_CREDITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_req_i,
  output logic              act_ack_o,
  input  logic              flit_valid_i,
  input  logic [FLIT_W-1:0] flit_i,
  output logic              credit_o,
  output logic              up_valid_o,
  input  logic              up_ready_i,
  output logic [FLIT_W-1:0] up_flit_o,
  output logic              up_crc_err_o,
  output logic              proto_err_o
);
  localparam int CRC_W  = 16;
  localparam int BODY_W = FLIT_W - CRC_W;
  localparam int PTR_W  = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
  localparam int CNT_W  = $clog2(BUF_DEPTH + 1);
  localparam int CR_W   = $clog2(INIT_CREDITS + 1);

  logic             ack_q, perr_q;
  logic [CR_W-1:0]  owed_q, held_q;
  logic [CNT_W-1:0] count_q;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [FLIT_W-1:0] mem [BUF_DEPTH];

  function automatic logic [CRC_W-1:0] crc_calc(input logic [BODY_W-1:0] d);
    logic [CRC_W-1:0] c;
    c = 16'hFFFF;
    for (int i = BODY_W - 1; i >= 0; i--)
      c = {c[CRC_W-2:0], 1'b0} ^ ((c[CRC_W-1] ^ d[i]) ? 16'h1021 : 16'h0000);
    return c;
  endfunction

  wire link_up  = act_req_i & ack_q;
  wire accept   = flit_valid_i & link_up & (held_q != '0);
  wire drain    = up_valid_o & up_ready_i;
  wire activate = ~ack_q & act_req_i;
  wire deact    = ack_q & ~act_req_i & (count_q == '0);

  assign act_ack_o    = ack_q;
  assign credit_o     = link_up & (owed_q != '0);
  assign up_valid_o   = (count_q != '0);
  assign up_flit_o    = mem[rd_ptr];
  assign up_crc_err_o = up_valid_o &
                        (crc_calc(up_flit_o[BODY_W-1:0]) != up_flit_o[FLIT_W-1:BODY_W]);
  assign proto_err_o  = perr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      perr_q  <= 1'b0;
      owed_q  <= '0;
      held_q  <= '0;
      count_q <= '0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
    end else begin
      perr_q <= flit_valid_i & ~accept;
      if (activate) begin
        ack_q  <= 1'b1;
        owed_q <= CR_W'(INIT_CREDITS);
        held_q <= '0;
      end else if (deact) begin
        ack_q  <= 1'b0;
        owed_q <= '0;
        held_q <= '0;
      end else begin
        owed_q <= owed_q + CR_W'(drain) - CR_W'(credit_o);
        held_q <= held_q + CR_W'(credit_o) - CR_W'(accept);
      end
      count_q <= count_q + CNT_W'(accept) - CNT_W'(drain);
      if (accept)
        wr_ptr <= (wr_ptr == PTR_W'(BUF_DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (drain)
        rd_ptr <= (rd_ptr == PTR_W'(BUF_DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= flit_i;
  end
endmodule

module flit_rx_ctrl_chk #(
  parameter int FLIT_W       = 256,
  parameter int INIT_CREDITS = 8,
  parameter int BUF_DEPTH    = 8,
  parameter int CNT_W        = 4,
  parameter int CR_W         = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              act_req_i,
  input logic              act_ack_o,
  input logic              flit_valid_i,
  input logic              credit_o,
  input logic              up_valid_o,
  input logic              up_ready_i,
  input logic [FLIT_W-1:0] up_flit_o,
  input logic              proto_err_o,
  input logic [CNT_W-1:0]  count_q,
  input logic [CR_W-1:0]   owed_q,
  input logic [CR_W-1:0]   held_q
);
  AST_ACK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_ack_o && act_req_i) |=> act_ack_o); // R2
  AST_CREDIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    credit_o |-> (act_req_i && act_ack_o)); // R4
  AST_CREDIT_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    act_ack_o |-> (32'(owed_q) + 32'(held_q) + 32'(count_q) == INIT_CREDITS)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count_q) <= BUF_DEPTH); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid_o && !up_ready_i) |=> (up_valid_o && $stable(up_flit_o))); // R5
  AST_DRAIN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_ack_o) |-> ($past(count_q) == '0 && !$past(act_req_i))); // R9
  AST_BAD_FLIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_valid_i && !(act_req_i && act_ack_o)) |=> proto_err_o); // R10
endmodule

bind flit_rx_ctrl flit_rx_ctrl_chk #(
  .FLIT_W(FLIT_W), .INIT_CREDITS(INIT_CREDITS), .BUF_DEPTH(BUF_DEPTH),
  .CNT_W(CNT_W), .CR_W(CR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .act_req_i(act_req_i), .act_ack_o(act_ack_o),
  .flit_valid_i(flit_valid_i), .credit_o(credit_o), .up_valid_o(up_valid_o),
  .up_ready_i(up_ready_i), .up_flit_o(up_flit_o), .proto_err_o(proto_err_o),
  .count_q(count_q), .owed_q(owed_q), .held_q(held_q)
);

// File: tb/flit_rx_ctrl_tb_top.sv
`timescale 1ns/1ps
module flit_rx_ctrl_tb_top;
  localparam int W  = 256;
  localparam int NC = 8;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, fv = 1'b0, ready = 1'b0;
  logic [W-1:0] fl = '0;
  logic ack, credit, uvalid, uerr, perr;
  logic [W-1:0] uflit;

  flit_rx_ctrl #(.FLIT_W(W), .INIT_CREDITS(NC)) dut_i (
    .clk(clk), .rst_n(rst_n), .act_req_i(req), .act_ack_o(ack),
    .flit_valid_i(fv), .flit_i(fl), .credit_o(credit), .up_valid_o(uvalid),
    .up_ready_i(ready), .up_flit_o(uflit), .up_crc_err_o(uerr), .proto_err_o(perr));

  always #2.5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  int held = 0, pulses = 0, pops = 0, err_pops = 0, perr_seen = 0;
  logic req_next = 1'b0;
  logic ob_ack, ob_cr, ob_uv, ob_pe;
  logic [W-1:0] ob_uf;
  logic [W:0] expq[$];

  function automatic logic [15:0] ref_crc(input logic [W-17:0] d);
    logic [15:0] c = 16'hFFFF;
    for (int i = W - 17; i >= 0; i--) begin
      logic fb = c[15] ^ d[i];
      c = c << 1;
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [W-1:0] mk(input bit bad);
    logic [W-17:0] b;
    for (int i = 0; i < W - 16; i += 8) b[i+:8] = 8'($urandom);
    return {ref_crc(b) ^ (bad ? 16'h0001 : 16'h0000), b};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input logic [W-1:0] f, input bit r);
    bit acc;
    @(negedge clk);
    req = req_next; fv = v; fl = f; ready = r;
    #1;
    ob_ack = ack; ob_cr = credit; ob_uv = uvalid; ob_uf = uflit; ob_pe = perr;
    acc = v && req && ack && held > 0;
    if (credit) begin held++; pulses++; end
    if (perr) perr_seen++;
    if (uvalid && r) begin
      logic [W:0] e;
      pops++;
      if (uerr) err_pops++;
      if (expq.size() == 0) chk(0, "R5 unexpected flit", uflit, '0);
      else begin
        e = expq.pop_front();
        chk(uflit == e[W-1:0], "R5 flit order/data", uflit, e[W-1:0]);
        chk(uerr == e[W], "R7 crc flag", W'(uerr), W'(e[W]));
      end
    end
    if (acc) begin
      held--;
      expq.push_back({ref_crc(f[W-17:0]) != f[W-1:W-16], f});
    end
  endtask

  task automatic idle(input int n, input bit r);
    repeat (n) cyc(0, '0, r);
  endtask

  task automatic t_reset;
    req_next = 1'b1;
    repeat (3) begin
      cyc(1, mk(0), 1);
      chk(!ob_ack && !ob_cr && !ob_uv && !ob_pe, "R1 outputs quiet in reset",
          W'({ob_ack, ob_cr, ob_uv, ob_pe}), '0);
    end
    req_next = 1'b0;
    idle(1, 0);
    rst_n = 1'b1;
    idle(2, 0);
    chk(!ob_ack && !ob_cr, "R1 idle after reset", W'({ob_ack, ob_cr}), '0);
    held = 0; expq.delete();
  endtask

  task automatic t_activate;
    int run = 0;
    pulses = 0;
    req_next = 1'b1;
    cyc(0, '0, 0);
    chk(ob_ack == 0, "R2 ack not yet", W'(ob_ack), '0);
    cyc(0, '0, 0);
    chk(ob_ack == 1, "R2 ack raised", W'(ob_ack), 1);
    if (ob_cr) run++;
    repeat (NC - 1) begin cyc(0, '0, 0); if (ob_cr) run++; end
    chk(run == NC, "R3 consecutive initial credits", W'(run), W'(NC));
    idle(4, 0);
    chk(pulses == NC, "R3 initial credit total", W'(pulses), W'(NC));
  endtask

  task automatic t_stream;
    logic [W-1:0] first;
    first = mk(0);
    pulses = 0; pops = 0; err_pops = 0;
    cyc(1, first, 0);
    repeat (3) cyc(1, mk(0), 0);
    cyc(1, mk(1), 0);
    idle(2, 0);
    chk(ob_uv == 1 && ob_uf == first, "R5 head held under backpressure", ob_uf, first);
    chk(pulses == 0, "R6 no credit before drain", W'(pulses), '0);
    idle(9, 1);
    chk(pops == 5, "R5 all flits delivered", W'(pops), 5);
    chk(err_pops == 1, "R7 one bad crc flagged", W'(err_pops), 1);
    chk(pulses == 5, "R6 credit per drained flit", W'(pulses), 5);
  endtask

  task automatic t_full;
    int pe0;
    pulses = 0; pops = 0;
    repeat (NC) cyc(1, mk(0), 0);
    pe0 = perr_seen;
    cyc(1, mk(0), 0);
    cyc(0, '0, 0);
    chk(perr_seen - pe0 == 1, "R10 flit without credit flagged", W'(perr_seen - pe0), 1);
    chk(pulses == 0, "R8 no credit while full", W'(pulses), '0);
    idle(NC + 3, 1);
    chk(pops == NC, "R8 full buffer delivered intact", W'(pops), W'(NC));
    chk(expq.size() == 0 && !ob_uv, "R10 extra flit discarded", W'(ob_uv), '0);
    chk(pulses == NC, "R6 credits returned after full drain", W'(pulses), W'(NC));
  endtask

  task automatic t_deact;
    int pe0, k;
    pulses = 0;
    cyc(1, mk(0), 0);
    cyc(1, mk(1), 0);
    req_next = 1'b0;
    repeat (3) begin
      cyc(0, '0, 0);
      chk(ob_ack == 1, "R9 ack held with flits buffered", W'(ob_ack), 1);
    end
    pe0 = perr_seen;
    cyc(1, mk(0), 0);
    cyc(0, '0, 0);
    chk(perr_seen - pe0 == 1, "R10 flit after request drop flagged", W'(perr_seen - pe0), 1);
    k = 0;
    do begin cyc(0, '0, 1); k++; end while (ob_uv && k < 8);
    chk(ob_ack == 1, "R9 ack up on first empty cycle", W'(ob_ack), 1);
    cyc(0, '0, 1);
    chk(ob_ack == 0, "R9 ack dropped after drain", W'(ob_ack), '0);
    chk(pulses == 0, "R4 no credit while request low", W'(pulses), '0);
    held = 0;
  endtask

  task automatic t_inactive;
    int pe0;
    pe0 = perr_seen;
    cyc(1, mk(0), 1);
    cyc(0, '0, 1);
    chk(perr_seen - pe0 == 1 && !ob_uv, "R10 flit on idle link discarded",
        W'(perr_seen - pe0), 1);
  endtask

  task automatic t_react;
    pulses = 0; pops = 0;
    req_next = 1'b1;
    idle(NC + 5, 0);
    chk(pulses == NC, "R9 full grant on reactivation", W'(pulses), W'(NC));
    cyc(1, mk(1), 0);
    idle(3, 1);
    chk(pops == 1, "R7 bad flit still delivered", W'(pops), 1);
  endtask

  initial begin
    t_reset;
    t_activate;
    t_stream;
    t_full;
    t_deact;
    t_inactive;
    t_react;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #250000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule